// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a windowed register file. Each procedure sees 32 logical registers: ten globals shared by every procedure, plus a window of its own made of six outgoing-argument registers, ten private locals and six incoming-argument registers. The outgoing registers of a caller occupy the same storage as the incoming registers of its callee, so arguments and results pass between procedures without any copy. Windows sit in a circular arrangement, so the incoming registers of window 0 are the outgoing registers of the last window.

A 5-bit logical register number is translated to a physical index using the current window pointer. There are two combinational read ports and one synchronous write port. A call request moves the pointer one window forward and a return request moves it one window back. The block counts live nested windows. It refuses a call that would overwrite the oldest live window, and it refuses a return when no caller is live. Each refusal is reported by a one-cycle flag. Saving windows to memory is handled elsewhere.

Top module: `rwin_regfile`

## Requirements
- R1: While reset is held low (synchronous, active low), every physical register clears to zero, the window pointer and live depth go to zero, and both flags go low.
- R2: Logical registers 0 to 9 are global: they name the same storage in every window.
- R3: Logical register 10+i (outgoing, i in 0..5) in window w and logical register 26+i (incoming) in window w+1 name the same storage.
- R4: Logical registers 16 to 25 (locals) are private: a write in one window is not visible through the same numbers in another window.
- R5: When call is high and return is low, the window pointer advances by one. When return is high and call is low, it steps back by one. Each live call raises the depth by one and each return lowers it by one.
- R6: A call made while the live depth is already 7 (number of windows minus one) is refused. The pointer and depth do not change, and overflow is high for the following cycle only.
- R7: A return made at live depth 0 is refused. The pointer does not change, and underflow is high for the following cycle only.
- R8: When call and return are high in the same cycle, neither takes effect and neither flag is raised.
- R9: A read of a register written in the same cycle returns the previous contents. The new value is visible from the next cycle.
- R10: With write enable low, the write address and data have no effect on any register.
- R11: A write issued in the same cycle as a call uses the window that was current before the call.
- R12: Window addressing wraps: the incoming registers of window 0 are the outgoing registers of window 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| call_i | input | 1 | Request to open the next window |
| ret_i | input | 1 | Request to go back to the previous window |
| rd_a_addr | input | 5 | Logical register for read port A |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_addr | input | 5 | Logical register for read port B |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register to write |
| wr_data | input | 32 | Write data |
| win_ovf | output | 1 | One-cycle pulse: call refused, all windows live |
| win_unf | output | 1 | One-cycle pulse: return refused, no live caller |

## Verification
The bench uses the default parameters: 8 windows, 10 globals, and 6 outgoing, 10 local and 6 incoming registers, which gives 138 physical registers. With only eight windows, a chain of seven calls fills every window. That makes the refused eighth call, the wrap from window 7 back to window 0, and the return chain to the first window all reachable within a few dozen cycles. The overlapped argument path is checked in both directions: caller to callee through the outgoing registers, and callee to caller through the incoming registers. Locals are shown to be private by checking that they differ between windows.

// File: rtl/rwin_pkg.sv
// Shared definitions for the windowed register file.
// Assumes the logical view is split, in ascending number order, into
// globals, outgoing, locals and incoming registers.
package rwin_pkg;

    // Part of the logical view that a register number falls in.
    typedef enum logic [1:0] {
        RG_GLOBAL = 2'd0,
        RG_OUT    = 2'd1,
        RG_LOCAL  = 2'd2,
        RG_IN     = 2'd3
    } rwin_region_e;

    // Operation requested on the window pointer in one cycle.
    typedef enum logic [1:0] {
        WOP_HOLD = 2'd0,
        WOP_CALL = 2'd1,
        WOP_RET  = 2'd2
    } rwin_op_e;

endpackage

// File: rtl/rwin_map.sv
// Translates a logical register number plus the current window into a
// physical register index.
// Assumes NWIN is a power of two, so the caller window wraps for free.
// Physical layout: the globals come first, then one stride per window
// holding its locals followed by its outgoing registers. A window's
// incoming registers are the outgoing registers of the window below it.
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int NGLOB  = 10,
    parameter int NIO    = 6,
    parameter int NLOC   = 10,
    parameter int LREG_W = 5,
    parameter int PREG_W = 8,
    parameter int WIN_W  = 3
) (
    input  logic [WIN_W-1:0]  cwp,
    input  logic [LREG_W-1:0] lreg,
    output logic [PREG_W-1:0] preg
);
    localparam int STRIDE  = NLOC + NIO;
    localparam int OUT_LO  = NGLOB;
    localparam int LOC_LO  = NGLOB + NIO;
    localparam int IN_LO   = LOC_LO + NLOC;

    logic [WIN_W-1:0] caller_win;
    rwin_region_e     region;
    int               lnum;
    int               idx;

    // Window that called the current one, used for incoming registers.
    assign caller_win = cwp - WIN_W'(1);

    // Classify the logical number into its part of the view.
    always_comb begin
        lnum = int'(lreg);
        if (lnum < OUT_LO)      region = RG_GLOBAL;
        else if (lnum < LOC_LO) region = RG_OUT;
        else if (lnum < IN_LO)  region = RG_LOCAL;
        else                    region = RG_IN;
    end

    // Compute the physical index for the selected part.
    always_comb begin
        case (region)
            RG_GLOBAL: idx = lnum;
            RG_OUT:    idx = NGLOB + int'(cwp) * STRIDE + NLOC + (lnum - OUT_LO);
            RG_LOCAL:  idx = NGLOB + int'(cwp) * STRIDE + (lnum - LOC_LO);
            default:   idx = NGLOB + int'(caller_win) * STRIDE + NLOC + (lnum - IN_LO);
        endcase
        preg = PREG_W'(idx);
    end

endmodule

// File: rtl/rwin_ptr.sv
// Current window pointer and live-depth tracker.
// Assumes NWIN is a power of two. A call is refused when the live depth
// is NWIN-1, a return is refused at depth 0, and a call and a return in
// the same cycle cancel each other. A refusal raises a one-cycle flag.
module rwin_ptr
    import rwin_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int WIN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_i,
    input  logic             ret_i,
    output logic [WIN_W-1:0] cwp,
    output logic [WIN_W-1:0] depth,
    output logic             ovf,
    output logic             unf
);
    localparam logic [WIN_W-1:0] DEPTH_MAX = WIN_W'(NWIN - 1);

    rwin_op_e op;

    // Reduce the two request pins to a single operation.
    always_comb begin
        if (call_i && !ret_i)      op = WOP_CALL;
        else if (ret_i && !call_i) op = WOP_RET;
        else                       op = WOP_HOLD;
    end

    // Move the pointer, or flag a refused move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp   <= '0;
            depth <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            unf <= 1'b0;
            case (op)
                WOP_CALL: begin
                    if (depth == DEPTH_MAX) begin
                        ovf <= 1'b1;
                    end else begin
                        cwp   <= cwp + WIN_W'(1);
                        depth <= depth + WIN_W'(1);
                    end
                end
                WOP_RET: begin
                    if (depth == '0) begin
                        unf <= 1'b1;
                    end else begin
                        cwp   <= cwp - WIN_W'(1);
                        depth <= depth - WIN_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rwin_store.sv
// Physical register storage: one synchronous write port and two
// combinational read ports. Reads return the contents from before any
// write in the same cycle. A synchronous reset clears every register.
module rwin_store #(
    parameter int NPHYS  = 138,
    parameter int DATA_W = 32,
    parameter int PREG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PREG_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [PREG_W-1:0] ra,
    output logic [DATA_W-1:0] rda,
    input  logic [PREG_W-1:0] rb,
    output logic [DATA_W-1:0] rdb
);
    logic [DATA_W-1:0] mem [NPHYS];

    // Clear on reset, otherwise store the enabled write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    // Combinational read ports.
    assign rda = mem[ra];
    assign rdb = mem[rb];

endmodule

// File: rtl/rwin_regfile.sv
// Top level of the windowed register file. Three translators (two read
// ports and one write port) share the current window pointer, which
// feeds the physical storage. Assumes
// NGLOB + 2*NIO + NLOC == 2**LREG_W and that NWIN is a power of two.
module rwin_regfile #(
    parameter int DATA_W = 32,
    parameter int NWIN   = 8,
    parameter int NGLOB  = 10,
    parameter int NIO    = 6,
    parameter int NLOC   = 10,
    parameter int LREG_W = $clog2(NGLOB + 2 * NIO + NLOC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [LREG_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [LREG_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [LREG_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              win_ovf,
    output logic              win_unf
);
    localparam int NPHYS  = NGLOB + NWIN * (NLOC + NIO);
    localparam int PREG_W = $clog2(NPHYS);
    localparam int WIN_W  = $clog2(NWIN);
    localparam int NPORT  = 3;

    logic [WIN_W-1:0]  cur_win;
    logic [WIN_W-1:0]  live_depth;
    logic [LREG_W-1:0] lq [NPORT];
    logic [PREG_W-1:0] pq [NPORT];

    // Gather the logical numbers: port 0 read A, 1 read B, 2 write.
    assign lq[0] = rd_a_addr;
    assign lq[1] = rd_b_addr;
    assign lq[2] = wr_addr;

    rwin_ptr #(
        .NWIN  (NWIN),
        .WIN_W (WIN_W)
    ) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .call_i (call_i),
        .ret_i  (ret_i),
        .cwp    (cur_win),
        .depth  (live_depth),
        .ovf    (win_ovf),
        .unf    (win_unf)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rwin_map #(
            .NWIN   (NWIN),
            .NGLOB  (NGLOB),
            .NIO    (NIO),
            .NLOC   (NLOC),
            .LREG_W (LREG_W),
            .PREG_W (PREG_W),
            .WIN_W  (WIN_W)
        ) u_map (
            .cwp  (cur_win),
            .lreg (lq[p]),
            .preg (pq[p])
        );
    end

    rwin_store #(
        .NPHYS  (NPHYS),
        .DATA_W (DATA_W),
        .PREG_W (PREG_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .wa    (pq[2]),
        .wd    (wr_data),
        .ra    (pq[0]),
        .rda   (rd_a_data),
        .rb    (pq[1]),
        .rdb   (rd_b_data)
    );

endmodule

// File: rtl/rwin_regfile_chk.sv
// Assertion checker for the window pointer behaviour of rwin_regfile.
// It is attached to the top module by the bind statement at the end of
// this file and only observes signals.
module rwin_regfile_chk #(
    parameter int NWIN  = 8,
    parameter int WIN_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             call_i,
    input logic             ret_i,
    input logic [WIN_W-1:0] cwp,
    input logic [WIN_W-1:0] depth,
    input logic             win_ovf,
    input logic             win_unf
);
    localparam logic [WIN_W-1:0] DEPTH_MAX = WIN_W'(NWIN - 1);

    logic [WIN_W-1:0] cwp_up;
    logic [WIN_W-1:0] cwp_dn;

    // Wrapped neighbours of the pointer, compared one cycle later.
    assign cwp_up = cwp + WIN_W'(1);
    assign cwp_dn = cwp - WIN_W'(1);

    // R5: an accepted call advances the pointer by one.
    assert_call_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && depth != DEPTH_MAX) |=> (cwp == $past(cwp_up)));

    // R5: an accepted return moves the pointer back by one.
    assert_ret_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && depth != '0) |=> (cwp == $past(cwp_dn)));

    // R6: overflow only follows a call made at full depth.
    assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_ovf |-> $past(call_i && !ret_i && depth == DEPTH_MAX));

    // R6: a refused call leaves the pointer where it was.
    assert_no_overflow_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_ovf |-> $stable(cwp));

    // R7: underflow only follows a return made at depth zero.
    assert_unf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_unf |-> ($past(ret_i && !call_i && depth == '0) && $stable(cwp)));

    // R8: simultaneous call and return do nothing and raise no flag.
    assert_both_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> ($stable(cwp) && !win_ovf && !win_unf));

endmodule

bind rwin_regfile rwin_regfile_chk #(
    .NWIN  (NWIN),
    .WIN_W (WIN_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .cwp     (cur_win),
    .depth   (live_depth),
    .win_ovf (win_ovf),
    .win_unf (win_unf)
);

// File: tb/test_rwin_regfile.sv
// Self-checking bench: a table of vectors walked by one loop, then
// directed tests for reset, full depth, wraparound and write-with-call.
module test_rwin_regfile;

    localparam logic [1:0] OP_NONE = 2'd0;
    localparam logic [1:0] OP_CALL = 2'd1;
    localparam logic [1:0] OP_RET  = 2'd2;
    localparam logic [1:0] OP_BOTH = 2'd3;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [31:0] ea;
        logic [4:0]  rb;
        logic [31:0] eb;
        logic        eo;
        logic        eu;
    } vec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 1'b0;
    logic        ret_i = 1'b0;
    logic [4:0]  rd_a_addr = '0;
    logic [31:0] rd_a_data;
    logic [4:0]  rd_b_addr = '0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        win_ovf;
    logic        win_unf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rwin_regfile i_rwin_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_i    (call_i),
        .ret_i     (ret_i),
        .rd_a_addr (rd_a_addr),
        .rd_a_data (rd_a_data),
        .rd_b_addr (rd_b_addr),
        .rd_b_data (rd_b_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .win_ovf   (win_ovf),
        .win_unf   (win_unf)
    );

    // Table: starts at window 0, depth 0, all registers zero.
    localparam int NVEC = 11;
    localparam vec_t TABLE [NVEC] = '{
        // R9: write global r3, the same-cycle read sees the old value
        '{4'd9,  OP_NONE, 1'b1, 5'd3,  32'h33,   5'd3,  32'h0,   5'd10, 32'h0,   1'b0, 1'b0},
        // R9: the new value is visible now; r10 written in window 0
        '{4'd9,  OP_NONE, 1'b1, 5'd10, 32'hA0,   5'd3,  32'h33,  5'd16, 32'h0,   1'b0, 1'b0},
        // R5: call; the write to local r16 goes to window 0
        '{4'd5,  OP_CALL, 1'b1, 5'd16, 32'h16,   5'd10, 32'hA0,  5'd3,  32'h33,  1'b0, 1'b0},
        // R3: callee r26 is caller r10; R4: local r16 is fresh
        '{4'd3,  OP_NONE, 1'b1, 5'd16, 32'h116,  5'd26, 32'hA0,  5'd16, 32'h0,   1'b0, 1'b0},
        // R2: global seen from window 1; write a result into r26
        '{4'd2,  OP_NONE, 1'b1, 5'd26, 32'hBB,   5'd16, 32'h116, 5'd3,  32'h33,  1'b0, 1'b0},
        // R10: write disabled while returning
        '{4'd10, OP_RET,  1'b0, 5'd3,  32'hDEAD, 5'd26, 32'hBB,  5'd3,  32'h33,  1'b0, 1'b0},
        // R3: caller sees the result in r10; R4: its own local
        '{4'd3,  OP_NONE, 1'b0, 5'd0,  32'h0,    5'd10, 32'hBB,  5'd16, 32'h16,  1'b0, 1'b0},
        // R7: return at depth 0 raises underflow; R10: r3 kept
        '{4'd7,  OP_RET,  1'b0, 5'd0,  32'h0,    5'd3,  32'h33,  5'd16, 32'h16,  1'b0, 1'b1},
        // R7: pointer still on window 0, flag gone
        '{4'd7,  OP_NONE, 1'b0, 5'd0,  32'h0,    5'd16, 32'h16,  5'd10, 32'hBB,  1'b0, 1'b0},
        // R8: call and return together
        '{4'd8,  OP_BOTH, 1'b0, 5'd0,  32'h0,    5'd16, 32'h16,  5'd0,  32'h0,   1'b0, 1'b0},
        // R8: still window 0
        '{4'd8,  OP_NONE, 1'b0, 5'd0,  32'h0,    5'd16, 32'h16,  5'd10, 32'hBB,  1'b0, 1'b0}
    };

    function automatic vec_t mk(input logic [3:0] req, input logic [1:0] op,
                                input logic we, input logic [4:0] wa,
                                input logic [31:0] wd, input logic [4:0] ra,
                                input logic [31:0] ea, input logic [4:0] rb,
                                input logic [31:0] eb, input logic eo,
                                input logic eu);
        vec_t v;
        v = '{req, op, we, wa, wd, ra, ea, rb, eb, eo, eu};
        return v;
    endfunction

    task automatic chk(input logic [3:0] req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, check reads before the edge, check flags after.
    task automatic cycle(input vec_t v);
        @(negedge clk);
        call_i    = v.op[0];
        ret_i     = v.op[1];
        wr_en     = v.we;
        wr_addr   = v.wa;
        wr_data   = v.wd;
        rd_a_addr = v.ra;
        rd_b_addr = v.rb;
        #1;
        chk(v.req, "read port A", rd_a_data, v.ea);
        chk(v.req, "read port B", rd_b_data, v.eb);
        @(posedge clk);
        #1;
        chk(v.req, "overflow flag", {31'd0, win_ovf}, {31'd0, v.eo});
        chk(v.req, "underflow flag", {31'd0, win_unf}, {31'd0, v.eu});
    endtask

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(4'd1, "overflow in reset", {31'd0, win_ovf}, 32'd0);
        chk(4'd1, "underflow in reset", {31'd0, win_unf}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 32; r++) begin
            rd_a_addr = 5'(r);
            rd_b_addr = 5'(31 - r);
            #0.2;
            chk(4'd1, "cleared register A", rd_a_data, 32'h0);
            chk(4'd1, "cleared register B", rd_b_data, 32'h0);
        end

        for (int i = 0; i < NVEC; i++) cycle(TABLE[i]);

        // R6: seven calls reach window 7 with depth 7
        for (int i = 0; i < 7; i++)
            cycle(mk(4'd6, OP_CALL, 1'b0, 5'd0, 32'h0, 5'd0, 32'h0, 5'd3, 32'h33, 1'b0, 1'b0));
        cycle(mk(4'd6, OP_NONE, 1'b1, 5'd10, 32'h77, 5'd16, 32'h0, 5'd0, 32'h0, 1'b0, 1'b0));
        cycle(mk(4'd6, OP_NONE, 1'b1, 5'd16, 32'h716, 5'd10, 32'h77, 5'd0, 32'h0, 1'b0, 1'b0));
        // R6: the eighth call is refused with overflow
        cycle(mk(4'd6, OP_CALL, 1'b0, 5'd0, 32'h0, 5'd16, 32'h716, 5'd10, 32'h77, 1'b1, 1'b0));
        // R6: still window 7, flag dropped
        cycle(mk(4'd6, OP_NONE, 1'b0, 5'd0, 32'h0, 5'd16, 32'h716, 5'd26, 32'h0, 1'b0, 1'b0));
        // R5: seven returns back to window 0
        for (int i = 0; i < 7; i++)
            cycle(mk(4'd5, OP_RET, 1'b0, 5'd0, 32'h0, 5'd3, 32'h33, 5'd0, 32'h0, 1'b0, 1'b0));
        // R12: window 0 incoming r26 is window 7 outgoing r10
        cycle(mk(4'd12, OP_NONE, 1'b0, 5'd0, 32'h0, 5'd26, 32'h77, 5'd16, 32'h16, 1'b0, 1'b0));
        // R11: write in the same cycle as a call lands in window 0
        cycle(mk(4'd11, OP_CALL, 1'b1, 5'd11, 32'h5A, 5'd10, 32'hBB, 5'd0, 32'h0, 1'b0, 1'b0));
        cycle(mk(4'd11, OP_NONE, 1'b0, 5'd0, 32'h0, 5'd27, 32'h5A, 5'd11, 32'h0, 1'b0, 1'b0));

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R0 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule